// File: doc/BRIEF.md
# Frame Buffer Data Request Handshake

This block sits between a host CPU and a frame-based audio decoder core. It owns a byte-wide circular input buffer. It runs the request and acknowledge exchange that refills the buffer one frame at a time. It raises three request indications with different lifetimes and an interrupt line. It tells the decoder when a complete frame is resident.

After the decoder is enabled, the first request asks for enough bytes to fill the whole buffer. Each later request asks for the frame length that the decoder side supplies. That request is armed by a frame-consumed pulse and raised only once the buffer has room for the whole frame. The CPU answers a request by writing bytes one at a time. Each accepted byte counts down the request, and the decoder drains bytes through a read strobe. Writes that nothing asked for are dropped and recorded in a sticky overrun bit. Clearing the enable returns the block to its initial state.

Top module: `fbuf_req_ctrl`

## Requirements
- R1: `frame_ready` is high only after the initial fill has completed and while the buffer holds at least `frame_len` bytes (`frame_len` nonzero). It reflects the occupancy and `frame_len` of the previous cycle.
- R2: A new request sets `req_flag`, `frame_req` and `byte_req` to 1 in the same cycle.
- R3: `irq` equals `req_flag` AND the `irq_en` value of the previous cycle.
- R4: A `stat_rd` pulse clears `req_flag` at the next edge unless a new request starts in that cycle. It leaves `frame_req` unchanged.
- R5: Each accepted write stores `cpu_wdata` in the buffer. A `dec_rd` pulse while the buffer is non-empty presents the oldest byte on `dec_rdata` one cycle later, in write order.
- R6: `byte_req` inverts on every accepted write.
- R7: `frame_req` stays high while requested bytes are outstanding. It falls at the edge that accepts the last requested byte.
- R8: The first request after enable asks for DEPTH (1024) bytes. `frame_req` is still high after DEPTH-1 writes and falls on write DEPTH.
- R9: After a `frame_done` pulse, a request for `frame_len` bytes starts only when the free space (DEPTH minus occupancy) is at least `frame_len`. It appears two edges after the read that made enough room.
- R10: A write with no active request, or with the buffer full, stores nothing, leaves `byte_req` unchanged and sets `overrun`. `overrun` stays set until disable.
- R11: With `dec_en` low (or `rst` high), the pointers and occupancy are zero, all flags, `irq`, `overrun` and `frame_ready` are 0, and the next enable starts a fresh DEPTH-byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Decoder enable; low clears the block |
| frame_len | input | 11 | Byte length of the next frame |
| frame_done | input | 1 | Pulse: decoder consumed a frame |
| dec_rd | input | 1 | Decoder byte read strobe |
| dec_rdata | output | 8 | Byte read out, valid the cycle after `dec_rd` |
| frame_ready | output | 1 | Complete frame resident |
| cpu_wr | input | 1 | CPU data write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| stat_rd | input | 1 | CPU status read strobe |
| irq_en | input | 1 | Interrupt enable for `req_flag` |
| req_flag | output | 1 | Sticky request flag |
| frame_req | output | 1 | Level flag for the whole request |
| byte_req | output | 1 | Toggle flag per accepted byte |
| overrun | output | 1 | Sticky ignored-write flag |
| irq | output | 1 | Interrupt |

## Verification
The bench fills the buffer across the initial 1024-byte request and checks that `frame_req` holds through byte 1023 and drops on byte 1024. A design with the wrong first-fill length or an off-by-one counter would release the flag early or late. It checks that `frame_ready` stays low mid-fill even though the occupancy already exceeds `frame_len`. A design that skipped that gate would start the decoder on a partial buffer. With the buffer full, it writes while no request is active, then reads back the oldest byte. A design that stored the stray byte would have overwritten that byte after the pointer wrapped, and one that toggled the byte flag would show it. It also holds a pending frame request until exactly enough space is free. An early request would let the CPU overrun the buffer.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

  typedef struct packed {
    logic req;    // sticky, cleared by status read
    logic frame;  // level over the whole request
    logic tgl;    // toggles on each accepted byte
    logic ovr;    // sticky ignored-write record
  } fbuf_flags_t;

endpackage

// File: rtl/fbuf_ring.sv
// Byte storage: one write port, one registered read port (block RAM friendly).
module fbuf_ring #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fbuf_occ.sv
// Pointers and occupancy count; DEPTH is a power of two so pointers wrap freely.
module fbuf_occ #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          wr_acc,
  input  logic          rd_req,
  output logic          rd_acc,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] count_q,
  output logic [LW-1:0] count_n,
  output logic          full
);

  assign full   = (count_q == LW'(DEPTH));
  assign rd_acc = rd_req && (count_q != '0);

  always_comb begin
    count_n = count_q;
    if (clear)                  count_n = '0;
    else if (wr_acc && !rd_acc) count_n = count_q + 1'b1;
    else if (!wr_acc && rd_acc) count_n = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    count_q <= count_n;
    if (clear) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      if (rd_acc) rptr <= rptr + 1'b1;
    end
  end

  // R11: clearing empties the buffer and rewinds both pointers
  p_clear_empties_r11: assert property (@(posedge clk)
    clear |=> (count_q == '0) && (wptr == '0) && (rptr == '0));

  // R10: occupancy never passes the buffer depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (clear)
    count_q <= LW'(DEPTH));

endmodule

// File: rtl/fbuf_req_seq.sv
// Request sequencer: outstanding byte count, the three flags, interrupt, frame gate.
module fbuf_req_seq
  import fbuf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] frame_len,
  input  logic          frame_done,
  input  logic          cpu_wr,
  input  logic          stat_rd,
  input  logic          irq_en,
  input  logic          full,
  input  logic [LW-1:0] count_q,
  input  logic [LW-1:0] count_n,
  output logic          wr_acc,
  output fbuf_flags_t   flags,
  output logic          irq,
  output logic          frame_ready
);

  logic [LW-1:0] need_q, need_n, free_sp;
  logic init_pend_q, init_act_q, armed_q, fill_done_q;
  logic start_init, start_frame, start, wr_bad, fill_done_n, last_byte;
  fbuf_flags_t flags_n;

  assign free_sp     = LW'(DEPTH) - count_q;
  assign start_init  = en && init_pend_q && (need_q == '0);
  assign start_frame = en && !init_pend_q && armed_q && (need_q == '0) &&
                       (frame_len != '0) && (free_sp >= frame_len);
  assign start       = start_init || start_frame;
  assign wr_acc      = en && cpu_wr && (need_q != '0) && !full;
  assign wr_bad      = en && cpu_wr && !wr_acc;
  assign last_byte   = wr_acc && (need_q == LW'(1));
  assign fill_done_n = fill_done_q || (init_act_q && last_byte);

  always_comb begin
    need_n = need_q;
    if (start_init)       need_n = LW'(DEPTH);
    else if (start_frame) need_n = frame_len;
    else if (wr_acc)      need_n = need_q - 1'b1;

    flags_n.req   = start || (flags.req && !stat_rd);
    flags_n.frame = (need_n != '0);
    flags_n.tgl   = start ? 1'b1 : (wr_acc ? !flags.tgl : flags.tgl);
    flags_n.ovr   = flags.ovr || wr_bad;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      need_q      <= '0;
      init_pend_q <= 1'b1;
      init_act_q  <= 1'b0;
      armed_q     <= 1'b0;
      fill_done_q <= 1'b0;
      flags       <= '0;
      irq         <= 1'b0;
      frame_ready <= 1'b0;
    end else begin
      need_q      <= need_n;
      init_pend_q <= init_pend_q && !start_init;
      init_act_q  <= start_init || (init_act_q && !last_byte);
      armed_q     <= (armed_q && !start_frame) || frame_done;
      fill_done_q <= fill_done_n;
      flags       <= flags_n;
      irq         <= flags_n.req && irq_en;
      frame_ready <= fill_done_n && (frame_len != '0) && (count_n >= frame_len);
    end
  end

  // R1: a ready frame is really resident
  p_frame_resident_r1: assert property (@(posedge clk) disable iff (rst)
    frame_ready |-> (count_q >= $past(frame_len)));

  // R2: a rising frame request comes with the other two flags set
  p_flags_together_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.frame) |-> (flags.req && flags.tgl));

  // R3: interrupt follows the sticky flag and the enable
  p_irq_follows_r3: assert property (@(posedge clk) disable iff (rst)
    irq == (flags.req && $past(irq_en)));

  // R4: status read clears the sticky flag
  p_stat_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !start) |=> !flags.req);

  // R6: each accepted byte flips the toggle flag
  p_byte_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> (flags.tgl != $past(flags.tgl)));

  // R10: a write with nothing requested is recorded as overrun
  p_idle_write_r10: assert property (@(posedge clk) disable iff (rst)
    (en && cpu_wr && !flags.frame) |=> flags.ovr);

endmodule

// File: rtl/fbuf_req_ctrl.sv
module fbuf_req_ctrl
  import fbuf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_en,
  input  logic [LW-1:0] frame_len,
  input  logic          frame_done,
  input  logic          dec_rd,
  output logic [DW-1:0] dec_rdata,
  output logic          frame_ready,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          stat_rd,
  input  logic          irq_en,
  output logic          req_flag,
  output logic          frame_req,
  output logic          byte_req,
  output logic          overrun,
  output logic          irq
);

  logic          clear, wr_acc, rd_acc, full;
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] count_q, count_n;
  fbuf_flags_t   flags;

  assign clear = rst || !dec_en;

  fbuf_occ #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .clear(clear), .wr_acc(wr_acc), .rd_req(dec_rd),
    .rd_acc(rd_acc), .wptr(wptr), .rptr(rptr),
    .count_q(count_q), .count_n(count_n), .full(full)
  );

  fbuf_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata(cpu_wdata),
    .re(rd_acc), .raddr(rptr), .rdata(dec_rdata)
  );

  fbuf_req_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .en(dec_en), .frame_len(frame_len),
    .frame_done(frame_done), .cpu_wr(cpu_wr), .stat_rd(stat_rd),
    .irq_en(irq_en), .full(full), .count_q(count_q), .count_n(count_n),
    .wr_acc(wr_acc), .flags(flags), .irq(irq), .frame_ready(frame_ready)
  );

  assign req_flag  = flags.req;
  assign frame_req = flags.frame;
  assign byte_req  = flags.tgl;
  assign overrun   = flags.ovr;

  // R11: disable leaves every flag low
  p_disable_quiet_r11: assert property (@(posedge clk)
    clear |=> !(req_flag || frame_req || byte_req || overrun || irq || frame_ready));

  // R7: the buffer only accepts bytes during a request
  p_write_in_request_r7: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> frame_req);

endmodule

// File: tb/fbuf_req_ctrl_test.sv
module fbuf_req_ctrl_test;

  localparam int DEPTH = 1024;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_en = 1'b0, frame_done = 1'b0, dec_rd = 1'b0;
  logic cpu_wr = 1'b0, stat_rd = 1'b0, irq_en = 1'b0;
  logic [LW-1:0] frame_len = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] dec_rdata;
  logic frame_ready, req_flag, frame_req, byte_req, overrun, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fbuf_req_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .dec_en(dec_en), .frame_len(frame_len),
    .frame_done(frame_done), .dec_rd(dec_rd), .dec_rdata(dec_rdata),
    .frame_ready(frame_ready), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .stat_rd(stat_rd), .irq_en(irq_en), .req_flag(req_flag),
    .frame_req(frame_req), .byte_req(byte_req), .overrun(overrun), .irq(irq)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d; step(); cpu_wr = 1'b0;
  endtask

  task automatic rd_byte();
    dec_rd = 1'b1; step(); dec_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(2);
    chk("R11 reset req_flag", req_flag, 0);
    chk("R11 reset frame_req", frame_req, 0);
    chk("R11 reset byte_req", byte_req, 0);
    chk("R11 reset overrun", overrun, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset frame_ready", frame_ready, 0);
    rst = 1'b0; step();
    chk("R11 no request while disabled", frame_req, 0);
  endtask

  task automatic t_first_request();
    irq_en = 1'b1; dec_en = 1'b1; step();
    chk("R2 req_flag set", req_flag, 1);
    chk("R2 frame_req set", frame_req, 1);
    chk("R2 byte_req set", byte_req, 1);
    chk("R3 irq with enable", irq, 1);
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    chk("R4 status read clears req_flag", req_flag, 0);
    chk("R4 frame_req kept", frame_req, 1);
    chk("R3 irq follows cleared flag", irq, 0);
  endtask

  task automatic t_init_fill();
    logic exp_tgl = 1'b1;
    frame_len = LW'(100);
    for (int i = 0; i < DEPTH - 1; i++) begin
      wr_byte(pat(i));
      exp_tgl = !exp_tgl;
      if (i < 3) chk("R6 byte_req toggles", byte_req, exp_tgl);
      if (i == 500) chk("R1 not ready mid-fill", frame_ready, 0);
    end
    chk("R8 frame_req held after DEPTH-1 bytes", frame_req, 1);
    chk("R1 not ready before fill ends", frame_ready, 0);
    wr_byte(pat(DEPTH - 1));
    chk("R8 frame_req drops on byte DEPTH", frame_req, 0);
    chk("R1 ready after initial fill", frame_ready, 1);
  endtask

  task automatic t_ignored_write();
    logic t0 = byte_req;
    wr_byte(8'hEE);
    chk("R10 overrun set", overrun, 1);
    chk("R10 byte_req unchanged", byte_req, t0);
    chk("R10 no request raised", frame_req, 0);
  endtask

  task automatic t_refill();
    irq_en = 1'b0;
    frame_done = 1'b1; step(); frame_done = 1'b0;
    step(3);
    chk("R9 no request while full", frame_req, 0);
    for (int i = 0; i < 99; i++) begin
      rd_byte();
      if (i < 4 || i == 98) chk("R5 read order", dec_rdata, pat(i));
    end
    step(3);
    chk("R9 no request with 99 free", frame_req, 0);
    rd_byte();
    chk("R5 read order last", dec_rdata, pat(99));
    chk("R9 request not yet one edge after read", frame_req, 0);
    step();
    chk("R9 request with 100 free", frame_req, 1);
    chk("R2 req_flag on later request", req_flag, 1);
    chk("R3 irq masked", irq, 0);
    for (int i = 0; i < 99; i++) wr_byte(pat(1000 + i));
    chk("R7 frame_req held mid-frame", frame_req, 1);
    wr_byte(pat(1099));
    chk("R7 frame_req drops on last byte", frame_req, 0);
    chk("R10 overrun sticky", overrun, 1);
    frame_len = LW'(DEPTH + 1); step();
    chk("R1 not ready when frame exceeds content", frame_ready, 0);
    frame_len = LW'(DEPTH); step();
    chk("R1 ready when frame equals content", frame_ready, 1);
  endtask

  task automatic t_disable();
    dec_en = 1'b0; step();
    chk("R11 flags clear", {req_flag, frame_req, byte_req, irq}, 0);
    chk("R11 overrun clear", overrun, 0);
    chk("R11 frame_ready clear", frame_ready, 0);
    dec_en = 1'b1; step();
    chk("R8 fresh request after re-enable", frame_req, 1);
    wr_byte(8'h5A);
    wr_byte(8'hA5);
    rd_byte();
    chk("R11 pointers rewound", dec_rdata, 8'h5A);
    chk("R8 re-armed fill still open", frame_req, 1);
  endtask

  initial begin
    step(200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_request();
    t_init_fill();
    t_ignored_write();
    t_refill();
    t_disable();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule